// File: doc/BRIEF.md
# Interrupt Classification and Masking Unit

This unit sits between the event sources of a parallel-bus controller and both the host CPU and the on-chip script sequencer. Every cycle it takes up to sixteen one-cycle event pulses. It records each one in a sticky status bit and sorts it as fatal or nonfatal. The sorting depends on whether the controller is acting as initiator or as target. A fatal event sends a one-cycle halt request to the sequencer. A nonfatal event lets scripted operation run on with no CPU service.

Enable bits decide which events reach the host. An enabled event raises a summary pending flag and pulls the active-low interrupt pin low. A masked event still sets its status bit, but it stays invisible to the host. The pin remembers which status bits caused it to assert. Clearing an enable bit later does not release the pin. Only clearing those status bits, or an explicit acknowledge, releases it.

Status and enable bits sit in two 8-bit banks. Software writes the enables and clears the status with write-one-to-clear strobes, one strobe per bank.

Top module: `irq_mask_unit`

## Requirements
- R1: A synchronous active-high reset clears all status and enable bits, clears the pending flag, drives the pin high and the halt request low.
- R2: Event bits 4 (reselected), 5 (selected), 6 (function complete), 8 (handshake timer), 9 (general timer) and 11 (on-the-fly) are nonfatal. Every other bit is fatal in initiator mode (`target_mode_i`=0). A fatal event drives `halt_req_o` high for exactly the one cycle after it, whether it is enabled or not.
- R3: In target mode, bit 7 (attention raised by the initiator) is nonfatal as well.
- R4: When `halt_dis_i` is 1 in target mode, bits 0 (parity error), 12 (CRC error) and 7 do not request a halt. In initiator mode `halt_dis_i` has no effect.
- R5: Any event sets its status bit on the next clock edge, whether its enable bit is set or not.
- R6: An event whose enable bit is 0 does not set the pending flag and does not pull the pin low.
- R7: An event whose enable bit is 1 sets `pend_o` and drives `irq_n_o` low on the next clock edge.
- R8: Clearing an enable bit after the pin has asserted does not deassert the pin.
- R9: Writing 1 to a status bit through a clear strobe clears that bit. The pin and flag deassert only once every status bit that asserted them is cleared.
- R10: When an event and a clear of the same bit arrive in one cycle, the bit stays set.
- R11: `en_wr_i[0]` and `sts_clr_i[0]` act on bits 7:0 through `wdata_i`. `en_wr_i[1]` and `sts_clr_i[1]` act on bits 15:8.
- R12: `pin_ack_i` deasserts the pin and the pending flag and leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 16 | One-cycle event pulses, one per bit |
| target_mode_i | input | 1 | 1 = target role, 0 = initiator role |
| halt_dis_i | input | 1 | Target-mode halt suppression for parity, CRC and attention |
| wdata_i | input | 8 | Write data for enable writes and status clears |
| en_wr_i | input | 2 | Enable write strobe per bank |
| sts_clr_i | input | 2 | Write-one-to-clear status strobe per bank |
| pin_ack_i | input | 1 | Releases the interrupt pin |
| status_o | output | 16 | Sticky event status |
| enable_o | output | 16 | Enable (mask) bits |
| pend_o | output | 1 | Summary pending flag |
| irq_n_o | output | 1 | Interrupt pin, active low |
| halt_req_o | output | 1 | One-cycle halt request to the sequencer |

## Verification
A table drives single events across all four combinations of role and halt-disable setting, each with the enables fully open or fully closed. This separates the fatal/nonfatal decision from the host-visibility decision: an event can halt without pending, pend without halting, or do both. Another vector enables a neighbouring bit and fires a different event, so a wrong bit mapping shows. Directed sequences then check the ordering cases: masking after the pin has asserted, two owners of the pin cleared one at a time, a clear that collides with an event, the acknowledge, and bank selection of writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int EVT_W  = 16;
  localparam int BANK_W = 8;
  localparam int NBANK  = EVT_W / BANK_W;

  // event bit positions
  localparam int B_PARITY   = 0;
  localparam int B_BUSRST   = 1;
  localparam int B_DISC     = 2;
  localparam int B_GROSS    = 3;
  localparam int B_RESEL    = 4;
  localparam int B_SEL      = 5;
  localparam int B_FDONE    = 6;
  localparam int B_ATN      = 7;
  localparam int B_HSTMR    = 8;
  localparam int B_GPTMR    = 9;
  localparam int B_SELTO    = 10;
  localparam int B_FLY      = 11;
  localparam int B_CRC      = 12;

  // events that never need CPU service in the given role
  function automatic logic [EVT_W-1:0] nonfatal_set(input logic tgt);
    logic [EVT_W-1:0] m;
    m = '0;
    m[B_RESEL] = 1'b1;
    m[B_SEL]   = 1'b1;
    m[B_FDONE] = 1'b1;
    m[B_HSTMR] = 1'b1;
    m[B_GPTMR] = 1'b1;
    m[B_FLY]   = 1'b1;
    m[B_ATN]   = tgt;
    return m;
  endfunction

  // events that still request a halt, given role and suppression bit
  function automatic logic [EVT_W-1:0] halt_set(input logic tgt, input logic hdis);
    logic [EVT_W-1:0] m;
    m = ~nonfatal_set(tgt);
    if (tgt && hdis) begin
      m[B_PARITY] = 1'b0;
      m[B_CRC]    = 1'b0;
      m[B_ATN]    = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqc_classify.sv
module irqc_classify
  import irqc_pkg::*;
(
  input  logic [EVT_W-1:0] evt,
  input  logic             tgt,
  input  logic             hdis,
  output logic [EVT_W-1:0] fatal_evt,
  output logic             halt_evt
);
  logic [EVT_W-1:0] halt_mask;

  always_comb begin
    halt_mask = halt_set(tgt, hdis);
    fatal_evt = evt & ~nonfatal_set(tgt);
    halt_evt  = |(evt & halt_mask);
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] wdata,
  input  logic         en_we,
  input  logic         clr_we,
  output logic [W-1:0] sts,
  output logic [W-1:0] sts_nxt,
  output logic [W-1:0] en
);
  logic [W-1:0] clr_bits;

  always_comb begin
    clr_bits = clr_we ? wdata : '0;
    // a new event wins over a clear in the same cycle
    sts_nxt  = (sts & ~clr_bits) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= sts_nxt;
      if (en_we) en <= wdata;
    end
  end
endmodule

// File: rtl/irqc_pin_ctl.sv
module irqc_pin_ctl #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] sts_nxt,
  input  logic         ack,
  input  logic         halt_evt,
  output logic         pend,
  output logic         irq_n,
  output logic         halt_req
);
  // status bits that currently hold the pin asserted
  logic [N-1:0] owner;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner    <= '0;
      halt_req <= 1'b0;
    end else begin
      halt_req <= halt_evt;
      if (ack) owner <= hit;
      else     owner <= (owner & sts_nxt) | hit;
    end
  end

  always_comb begin
    pend  = |owner;
    irq_n = ~pend;
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             target_mode_i,
  input  logic             halt_dis_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [NBANK-1:0] en_wr_i,
  input  logic [NBANK-1:0] sts_clr_i,
  input  logic             pin_ack_i,
  output logic [EVT_W-1:0] status_o,
  output logic [EVT_W-1:0] enable_o,
  output logic             pend_o,
  output logic             irq_n_o,
  output logic             halt_req_o
);
  logic [EVT_W-1:0] sts_nxt_w;
  logic [EVT_W-1:0] fatal_w;
  logic [EVT_W-1:0] hit_w;
  logic             halt_evt_w;

  irqc_classify u_cls (
    .evt       (evt_i),
    .tgt       (target_mode_i),
    .hdis      (halt_dis_i),
    .fatal_evt (fatal_w),
    .halt_evt  (halt_evt_w)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irqc_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_i[b*BANK_W +: BANK_W]),
      .wdata   (wdata_i),
      .en_we   (en_wr_i[b]),
      .clr_we  (sts_clr_i[b]),
      .sts     (status_o[b*BANK_W +: BANK_W]),
      .sts_nxt (sts_nxt_w[b*BANK_W +: BANK_W]),
      .en      (enable_o[b*BANK_W +: BANK_W])
    );
  end

  assign hit_w = evt_i & enable_o;

  irqc_pin_ctl #(.N(EVT_W)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit_w),
    .sts_nxt  (sts_nxt_w),
    .ack      (pin_ack_i),
    .halt_evt (halt_evt_w),
    .pend     (pend_o),
    .irq_n    (irq_n_o),
    .halt_req (halt_req_o)
  );
endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] evt_i,
  input logic        target_mode_i,
  input logic [1:0]  sts_clr_i,
  input logic        pin_ack_i,
  input logic [15:0] status_o,
  input logic [15:0] enable_o,
  input logic        pend_o,
  input logic        irq_n_o,
  input logic        halt_req_o,
  input logic        halt_evt_w
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (status_o == 16'h0 && enable_o == 16'h0 && !pend_o && irq_n_o && !halt_req_o)); // R1
  AST_FATAL_HALTS: assert property (@(posedge clk) disable iff (rst)
    halt_evt_w |=> halt_req_o); // R2
  AST_HALT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    !halt_evt_w |=> !halt_req_o); // R2
  AST_TGT_NONFATAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (target_mode_i && ((evt_i & 16'hF40F) == 16'h0)) |=> !halt_req_o); // R3
  AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (evt_i != 16'h0) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R5
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!pend_o && ((evt_i & enable_o) == 16'h0)) |=> !pend_o); // R6
  AST_UNMASKED_PENDS: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & enable_o) != 16'h0) |=> (pend_o && !irq_n_o)); // R7
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !pin_ack_i && sts_clr_i == 2'b00) |=> pend_o); // R8
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (rst)
    pend_o != irq_n_o); // R7
endmodule

bind irq_mask_unit irq_mask_unit_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .evt_i         (evt_i),
  .target_mode_i (target_mode_i),
  .sts_clr_i     (sts_clr_i),
  .pin_ack_i     (pin_ack_i),
  .status_o      (status_o),
  .enable_o      (enable_o),
  .pend_o        (pend_o),
  .irq_n_o       (irq_n_o),
  .halt_req_o    (halt_req_o),
  .halt_evt_w    (halt_evt_w)
);

// File: tb/irq_mask_unit_tb.sv
module irq_mask_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_i = '0;
  logic        target_mode_i = 1'b0;
  logic        halt_dis_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [1:0]  en_wr_i = '0;
  logic [1:0]  sts_clr_i = '0;
  logic        pin_ack_i = 1'b0;
  logic [15:0] status_o, enable_o;
  logic        pend_o, irq_n_o, halt_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_mask_unit u_dut (.*);

  // {tgt, hdis, enable[15:0], event[15:0], exp_halt, exp_pend}
  localparam logic [35:0] VEC [12] = '{
    {1'b0, 1'b0, 16'h0000, 16'h0040, 1'b0, 1'b0}, // R6 masked nonfatal
    {1'b0, 1'b0, 16'hFFFF, 16'h0040, 1'b0, 1'b1}, // R7 enabled nonfatal
    {1'b0, 1'b0, 16'h0000, 16'h0080, 1'b1, 1'b0}, // R2 attention fatal as initiator
    {1'b1, 1'b0, 16'h0000, 16'h0080, 1'b0, 1'b0}, // R3 attention nonfatal as target
    {1'b1, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b0}, // R2 parity fatal
    {1'b1, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0}, // R4 parity suppressed
    {1'b1, 1'b1, 16'h0000, 16'h1000, 1'b0, 1'b0}, // R4 crc suppressed
    {1'b0, 1'b1, 16'h0000, 16'h0001, 1'b1, 1'b0}, // R4 no effect as initiator
    {1'b0, 1'b0, 16'h0800, 16'h0800, 1'b0, 1'b1}, // R7 on-the-fly enabled
    {1'b1, 1'b0, 16'h0004, 16'h0004, 1'b1, 1'b1}, // R2 R7 fatal and enabled
    {1'b0, 1'b0, 16'h0200, 16'h0100, 1'b0, 1'b0}, // R6 neighbour enabled only
    {1'b1, 1'b0, 16'h8000, 16'h8000, 1'b1, 1'b1}  // R2 top bit fatal
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  task automatic write_en(input logic [15:0] v);
    wdata_i = v[7:0];  en_wr_i = 2'b01; step();
    wdata_i = v[15:8]; en_wr_i = 2'b10; step();
    en_wr_i = 2'b00;
  endtask

  task automatic clear(input logic [1:0] bank, input logic [7:0] bits);
    wdata_i = bits; sts_clr_i = bank; step();
    sts_clr_i = 2'b00;
  endtask

  task automatic pulse(input logic [15:0] e);
    evt_i = e; step();
    evt_i = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 status", status_o, 16'h0);
    check("R1 enable", enable_o, 16'h0);
    check("R1 pin/pend/halt", {13'h0, irq_n_o, pend_o, halt_req_o}, 16'h0004);

    for (int i = 0; i < 12; i++) begin
      do_reset();
      target_mode_i = VEC[i][35];
      halt_dis_i    = VEC[i][34];
      write_en(VEC[i][33:18]);
      evt_i = VEC[i][17:2];
      step();
      evt_i = '0;
      check("R5 status capture", status_o, VEC[i][17:2]);
      check("R2 R3 R4 halt", {15'h0, halt_req_o}, {15'h0, VEC[i][1]});
      check("R6 R7 pend", {15'h0, pend_o}, {15'h0, VEC[i][0]});
      check("R7 pin", {15'h0, irq_n_o}, {15'h0, ~VEC[i][0]});
      step();
      check("R2 halt one cycle", {15'h0, halt_req_o}, 16'h0);
    end
    target_mode_i = 1'b0;
    halt_dis_i = 1'b0;

    // R11 bank mapping of enable writes
    do_reset();
    wdata_i = 8'hA5; en_wr_i = 2'b10; step(); en_wr_i = 2'b00;
    check("R11 upper bank enable", enable_o, 16'hA500);
    wdata_i = 8'h3C; en_wr_i = 2'b01; step(); en_wr_i = 2'b00;
    check("R11 lower bank enable", enable_o, 16'hA53C);

    // R8 mask after assertion keeps pin low
    do_reset();
    write_en(16'h0040);
    pulse(16'h0040);
    check("R7 pin low", {15'h0, irq_n_o}, 16'h0);
    write_en(16'h0000);
    check("R8 pin held after mask", {15'h0, irq_n_o}, 16'h0);
    check("R8 pend held after mask", {15'h0, pend_o}, 16'h1);

    // R9 two owners cleared one at a time
    do_reset();
    write_en(16'h0120);
    pulse(16'h0120);
    clear(2'b01, 8'h20);
    check("R9 status after one clear", status_o, 16'h0100);
    check("R9 pin still low", {15'h0, irq_n_o}, 16'h0);
    clear(2'b01, 8'h01);
    check("R11 clear hits own bank only", status_o, 16'h0100);
    clear(2'b10, 8'h01);
    check("R9 status empty", status_o, 16'h0);
    check("R9 pin released", {15'h0, irq_n_o}, 16'h1);

    // R10 event wins over a simultaneous clear
    do_reset();
    pulse(16'h0010);
    evt_i = 16'h0010; wdata_i = 8'h10; sts_clr_i = 2'b01; step();
    evt_i = '0; sts_clr_i = 2'b00;
    check("R10 event beats clear", status_o, 16'h0010);

    // R12 acknowledge releases pin, keeps status
    do_reset();
    write_en(16'h0800);
    pulse(16'h0800);
    pin_ack_i = 1'b1; step(); pin_ack_i = 1'b0;
    check("R12 pin released", {14'h0, irq_n_o, pend_o}, 16'h0002);
    check("R12 status kept", status_o, 16'h0800);

    // R1 reset after activity
    do_reset();
    check("R1 reset clears status", status_o, 16'h0);
    check("R1 reset clears enables", enable_o, 16'h0);

    finish_run();
  end
endmodule